// File: doc/BRIEF.md
# E1 Loop-Back Code Detector

The block watches a received E1 bit stream for two programmable repeating loop-back codes, one asking the far end to close a line loop and one asking it to open the loop again. Each code has its own tracker. The tracker first finds the code's phase in the incoming bits. It then counts mismatches against the rotating expected pattern over fixed windows of counted bits. A code is reported present only after a full window has passed with few enough errors.

The window length and the error limit are parameters. At 2.048 Mbit/s a 25 ms window is 51,200 bits, and an error rate below 1e-2 allows at most 511 errors in it. When the receive framer is aligned, bits that belong to timeslot 0 are left out of both phase search and error counting. A mode input switches the activation status output so that it shows the state of an external PRBS synchronizer. Any change of either status output raises a one-cycle interrupt pulse.

Top module: `lb_code_det`

## Requirements
- R1: A status bit for a code sets only after the tracker has locked onto the code's phase and has then completed one full window of WIN_BITS counted bits with at most ERR_MAX mismatches. If the window is one counted bit short, the status stays clear.
- R2: Once set, a status bit stays set across every following window whose mismatch count is at most ERR_MAX. At the end of a window with more than ERR_MAX mismatches it clears, and the tracker returns to phase search.
- R3: A received bit is counted only when bit_en_i is high and it is not the case that both frm_aligned_i and ts0_bit_i are high. Uncounted bits do not affect phase search or the error count.
- R4: Every change of act_det_o or deact_det_o, rising or falling, produces chg_irq_o high for exactly one clock cycle, in the cycle in which the output shows its new value.
- R5: While prbs_mode_i is 1, act_det_o shows prbs_sync_i, delayed by one clock. While it is 0, act_det_o shows the activation tracker.
- R6: Codes are right-justified in an 8-bit field. The length field holds the code length minus one, so lengths run from 1 to 8. Bit `len` of the code is the first bit received in each period, and bit 0 is the last.
- R7: Phase lock is taken on the counted bit at which the most recent length-many counted bits equal the code exactly, with the oldest bit matching bit `len`. The window starts with the next counted bit.
- R8: After reset, act_det_o, deact_det_o and chg_irq_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Received bit valid in this cycle |
| rx_bit_i | input | 1 | Received serial data bit |
| ts0_bit_i | input | 1 | Current bit belongs to timeslot 0 |
| frm_aligned_i | input | 1 | Receive framer is aligned |
| act_code_i | input | 8 | Activation code, right-justified |
| act_len_i | input | 3 | Activation code length minus one |
| deact_code_i | input | 8 | Deactivation code, right-justified |
| deact_len_i | input | 3 | Deactivation code length minus one |
| prbs_sync_i | input | 1 | PRBS synchronizer in sync |
| prbs_mode_i | input | 1 | 1: act_det_o shows prbs_sync_i |
| act_det_o | output | 1 | Activation code detected, or PRBS sync in PRBS mode |
| deact_det_o | output | 1 | Deactivation code detected |
| chg_irq_o | output | 1 | One-cycle pulse on any status change |

## Verification
Some rules are checked by assertions on every cycle. The interrupt must match every edge of either status output. In PRBS mode the activation output must follow the synchronizer input one cycle later. The deactivation status may only rise or fall two cycles after a counted bit, never after an idle or skipped timeslot-0 bit. Other behaviour can only be shown by the bench's streams: the exact bit count at which a status first sets, tolerance of a single error per window, loss of status after two errors, exclusion of timeslot-0 garbage only when aligned, and a one-bit code.

// File: rtl/lb_code_pkg.sv
package lb_code_pkg;
  typedef enum logic {
    TRK_SEARCH = 1'b0,
    TRK_LOCK   = 1'b1
  } trk_state_e;

  localparam int unsigned NUM_CODES = 2;
  localparam int unsigned ACT_IDX   = 0;
  localparam int unsigned DEACT_IDX = 1;
endpackage

// File: rtl/lb_code_track.sv
module lb_code_track
  import lb_code_pkg::*;
#(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned WIN_BITS = 51200,
  parameter int unsigned ERR_MAX  = 511
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bit_vld_i,
  input  logic                      bit_i,
  input  logic [CODE_W-1:0]         code_i,
  input  logic [$clog2(CODE_W)-1:0] len_i,
  output logic                      det_o
);
  localparam int unsigned LEN_W = $clog2(CODE_W);
  localparam int unsigned WIN_W = $clog2(WIN_BITS);
  localparam int unsigned ERR_W = $clog2(ERR_MAX + 2);
  localparam logic [ERR_W-1:0] ERR_SAT = ERR_W'(ERR_MAX + 1);
  localparam logic [WIN_W-1:0] WIN_END = WIN_W'(WIN_BITS - 1);

  trk_state_e        state_q;
  logic [CODE_W-1:0] hist_q;
  logic [LEN_W:0]    fill_q;
  logic [LEN_W-1:0]  ptr_q;
  logic [WIN_W-1:0]  win_q;
  logic [ERR_W-1:0]  err_q;
  logic              det_q;

  logic [CODE_W-1:0] len_mask;
  logic [CODE_W-1:0] hist_nxt;
  logic [LEN_W:0]    len_ext;
  logic              hist_match;
  logic              miss;
  logic [ERR_W-1:0]  err_nxt;

  always_comb begin
    for (int i = 0; i < CODE_W; i++) begin
      len_mask[i] = (i <= int'(len_i));
    end
  end

  assign len_ext    = {1'b0, len_i};
  assign hist_nxt   = {hist_q[CODE_W-2:0], bit_i};
  assign hist_match = (((hist_nxt ^ code_i) & len_mask) == '0);
  assign miss       = bit_i ^ code_i[ptr_q];
  assign err_nxt    = (err_q == ERR_SAT) ? ERR_SAT : err_q + ERR_W'(miss);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TRK_SEARCH;
      hist_q  <= '0;
      fill_q  <= '0;
      ptr_q   <= '0;
      win_q   <= '0;
      err_q   <= '0;
      det_q   <= 1'b0;
    end else if (bit_vld_i) begin
      case (state_q)
        TRK_SEARCH: begin
          hist_q <= hist_nxt;
          if (fill_q >= len_ext && hist_match) begin
            // oldest matched bit was code[len]; next expected is code[len] again
            state_q <= TRK_LOCK;
            ptr_q   <= len_i;
            win_q   <= '0;
            err_q   <= '0;
          end else if (fill_q < len_ext) begin
            fill_q <= fill_q + 1'b1;
          end
        end
        TRK_LOCK: begin
          ptr_q <= (ptr_q == '0) ? len_i : ptr_q - 1'b1;
          if (win_q == WIN_END) begin
            win_q <= '0;
            err_q <= '0;
            if (err_nxt > ERR_W'(ERR_MAX)) begin
              det_q   <= 1'b0;
              state_q <= TRK_SEARCH;
              fill_q  <= '0;
            end else begin
              det_q <= 1'b1;
            end
          end else begin
            win_q <= win_q + 1'b1;
            err_q <= err_nxt;
          end
        end
        default: state_q <= TRK_SEARCH;
      endcase
    end
  end

  assign det_o = det_q;
endmodule

// File: rtl/lb_sts_irq.sv
module lb_sts_irq
  import lb_code_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CODES-1:0] trk_det_i,
  input  logic                 prbs_sync_i,
  input  logic                 prbs_mode_i,
  output logic [NUM_CODES-1:0] sts_o,
  output logic                 irq_o
);
  logic [NUM_CODES-1:0] sts_d, sts_q, prv_q;

  always_comb begin
    sts_d = trk_det_i;
    if (prbs_mode_i) sts_d[ACT_IDX] = prbs_sync_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      prv_q <= '0;
    end else begin
      sts_q <= sts_d;
      prv_q <= sts_q;
    end
  end

  assign sts_o = sts_q;
  assign irq_o = |(sts_q ^ prv_q);
endmodule

// File: rtl/lb_code_det.sv
module lb_code_det
  import lb_code_pkg::*;
#(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned WIN_BITS = 51200,
  parameter int unsigned ERR_MAX  = 511
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bit_en_i,
  input  logic                      rx_bit_i,
  input  logic                      ts0_bit_i,
  input  logic                      frm_aligned_i,
  input  logic [CODE_W-1:0]         act_code_i,
  input  logic [$clog2(CODE_W)-1:0] act_len_i,
  input  logic [CODE_W-1:0]         deact_code_i,
  input  logic [$clog2(CODE_W)-1:0] deact_len_i,
  input  logic                      prbs_sync_i,
  input  logic                      prbs_mode_i,
  output logic                      act_det_o,
  output logic                      deact_det_o,
  output logic                      chg_irq_o
);
  localparam int unsigned LEN_W = $clog2(CODE_W);

  logic                 bit_vld;
  logic [CODE_W-1:0]    code_arr [NUM_CODES];
  logic [LEN_W-1:0]     len_arr  [NUM_CODES];
  logic [NUM_CODES-1:0] trk_det;
  logic [NUM_CODES-1:0] sts;

  // timeslot 0 is only skipped while the framer is aligned
  assign bit_vld = bit_en_i & ~(frm_aligned_i & ts0_bit_i);

  assign code_arr[ACT_IDX]   = act_code_i;
  assign code_arr[DEACT_IDX] = deact_code_i;
  assign len_arr[ACT_IDX]    = act_len_i;
  assign len_arr[DEACT_IDX]  = deact_len_i;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_trk
    lb_code_track #(
      .CODE_W  (CODE_W),
      .WIN_BITS(WIN_BITS),
      .ERR_MAX (ERR_MAX)
    ) trk_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .bit_vld_i(bit_vld),
      .bit_i    (rx_bit_i),
      .code_i   (code_arr[g]),
      .len_i    (len_arr[g]),
      .det_o    (trk_det[g])
    );
  end

  lb_sts_irq sts_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trk_det_i  (trk_det),
    .prbs_sync_i(prbs_sync_i),
    .prbs_mode_i(prbs_mode_i),
    .sts_o      (sts),
    .irq_o      (chg_irq_o)
  );

  assign act_det_o   = sts[ACT_IDX];
  assign deact_det_o = sts[DEACT_IDX];
endmodule

// File: rtl/lb_code_det_chk.sv
module lb_code_det_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic ts0_bit_i,
  input logic frm_aligned_i,
  input logic prbs_sync_i,
  input logic prbs_mode_i,
  input logic act_det_o,
  input logic deact_det_o,
  input logic chg_irq_o
);
  // R4
  irq_on_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(act_det_o) || !$stable(deact_det_o)) |-> chg_irq_o);

  // R4
  irq_only_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_irq_o |-> (!$stable(act_det_o) || !$stable(deact_det_o)));

  // R5
  prbs_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prbs_mode_i |=> (act_det_o == $past(prbs_sync_i)));

  // R3
  deact_rise_counted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(deact_det_o) |-> ($past(bit_en_i, 2) && !$past(frm_aligned_i && ts0_bit_i, 2)));

  // R2
  deact_fall_counted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(deact_det_o) |-> ($past(bit_en_i, 2) && !$past(frm_aligned_i && ts0_bit_i, 2)));
endmodule

bind lb_code_det lb_code_det_chk chk_i (.*);

// File: tb/lb_code_det_tb_top.sv
`timescale 1ns/1ps
module lb_code_det_tb_top;
  localparam int WIN = 64;
  localparam int EMX = 1;
  localparam logic [7:0] ACT_C = 8'b0000_0001;
  localparam logic [2:0] ACT_L = 3'd4;
  localparam logic [7:0] DEA_C = 8'b0000_0001;
  localparam logic [2:0] DEA_L = 3'd2;
  localparam logic [7:0] NO_E  = 8'hFF;

  typedef struct packed {
    logic       sel;
    logic [7:0] nbits;
    logic [7:0] e1;
    logic [7:0] e2;
    logic       ts0g;
    logic       algn;
    logic       mode;
    logic       prbs;
    logic       x_act;
    logic       x_dea;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd68, NO_E,  NO_E,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 one bit short
    '{1'b0, 8'd69, NO_E,  NO_E,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R1 R7 exact
    '{1'b1, 8'd67, NO_E,  NO_E,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 3-bit code
    '{1'b0, 8'd69, 8'd20, NO_E,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R1 one error ok
    '{1'b0, 8'd69, 8'd20, 8'd40, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 two errors
    '{1'b0, 8'd69, NO_E,  NO_E,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 ts0 skipped
    '{1'b0, 8'd69, NO_E,  NO_E,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 ts0 counted
    '{1'b0, 8'd69, NO_E,  NO_E,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 prbs low
    '{1'b1, 8'd67, NO_E,  NO_E,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}  // R5 prbs high
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic bit_en_i = 0, rx_bit_i = 0, ts0_bit_i = 0, frm_aligned_i = 0;
  logic [7:0] act_code_i = ACT_C, deact_code_i = DEA_C;
  logic [2:0] act_len_i = ACT_L, deact_len_i = DEA_L;
  logic prbs_sync_i = 0, prbs_mode_i = 0;
  logic act_det_o, deact_det_o, chg_irq_o;

  int n_chk = 0, n_fail = 0, irq_cnt = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  lb_code_det #(.CODE_W(8), .WIN_BITS(WIN), .ERR_MAX(EMX)) dut_i (.*);

  always @(negedge clk_i) if (rst_ni && chg_irq_o) irq_cnt++;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    bit_en_i = 0; ts0_bit_i = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    irq_cnt = 0;
  endtask

  task automatic send_bit(input logic b, input logic ts0);
    bit_en_i = 1'b1; rx_bit_i = b; ts0_bit_i = ts0;
    @(negedge clk_i);
    bit_en_i = 1'b0; rx_bit_i = ~b; ts0_bit_i = 1'b0;
    @(negedge clk_i);
  endtask

  // counted bits start..start+n-1 of the repeating code; code[len] first
  task automatic send_stream(input logic [7:0] code, input int len, input int start,
                             input int n, input int e1, input int e2, input bit ts0g);
    for (int i = start; i < start + n; i++) begin
      logic b;
      b = code[len - (i % (len + 1))];
      if (ts0g && i >= 8 && (i % 16) == 8) send_bit(~b, 1'b1);
      if (i == e1 || i == e2) b = ~b;
      send_bit(b, 1'b0);
    end
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    do_reset();
    // R8
    chk("R8 act reset", act_det_o, 1'b0);
    chk("R8 deact reset", deact_det_o, 1'b0);
    chk("R8 irq reset", chg_irq_o, 1'b0);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VECS[v];
      do_reset();
      frm_aligned_i = t.algn; prbs_mode_i = t.mode; prbs_sync_i = t.prbs;
      send_stream(t.sel ? DEA_C : ACT_C, t.sel ? int'(DEA_L) : int'(ACT_L), 0,
                  int'(t.nbits), (t.e1 == NO_E) ? -1 : int'(t.e1),
                  (t.e2 == NO_E) ? -1 : int'(t.e2), t.ts0g);
      chk($sformatf("R1/R3/R5/R6/R7 vec %0d act", v), act_det_o, t.x_act);
      chk($sformatf("R1/R3/R5/R6/R7 vec %0d deact", v), deact_det_o, t.x_dea);
      frm_aligned_i = 0; prbs_mode_i = 0; prbs_sync_i = 0;
    end

    // R2 R4: persist, then clear, with interrupt count
    do_reset();
    send_stream(ACT_C, 4, 0, 69, -1, -1, 0);
    chk("R1 set", act_det_o, 1'b1);
    chk("R4 one pulse on set", irq_cnt == 1, 1'b1);
    send_stream(ACT_C, 4, 69, WIN, -1, 100, 0);
    chk("R2 held", act_det_o, 1'b1);
    chk("R4 no pulse while held", irq_cnt == 1, 1'b1);
    send_stream(ACT_C, 4, 133, WIN, 140, 150, 0);
    chk("R2 cleared", act_det_o, 1'b0);
    chk("R4 pulse on clear", irq_cnt == 2, 1'b1);

    // R5 R4: prbs mode
    prbs_mode_i = 1; prbs_sync_i = 1;
    repeat (3) @(negedge clk_i);
    chk("R5 prbs high", act_det_o, 1'b1);
    prbs_sync_i = 0;
    repeat (3) @(negedge clk_i);
    chk("R5 prbs low", act_det_o, 1'b0);
    chk("R4 prbs pulses", irq_cnt == 4, 1'b1);
    prbs_mode_i = 0;

    // R6: one-bit code, all ones
    do_reset();
    act_code_i = 8'h01; act_len_i = 3'd0;
    send_stream(8'h01, 0, 0, WIN, -1, -1, 0);
    chk("R6 len1 short", act_det_o, 1'b0);
    send_stream(8'h01, 0, WIN, 1, -1, -1, 0);
    chk("R6 len1 set", act_det_o, 1'b1);
    chk("R6 deact no match", deact_det_o, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule